// File: doc/BRIEF.md
# Dual-Channel DMA Control Register Bank

This block holds the software-visible control and status registers of a DMA engine serving two peripheral channels: a disk channel and a network channel. A 32-bit CPU bus reads and writes eight word registers. Writes to the two channel control words have side effects. They stamp a fixed version nibble, tidy certain bits and can fire a one-cycle reset pulse at the attached peripheral. They can also drop that channel's interrupt line.

The disk channel also takes events from its peripheral. A raise request sets the pending flag and asserts the disk interrupt line, and a clear request undoes both. A completion event carries a byte count: it sets the pending flag and advances the disk address register by that count. Any CPU write to the disk address marks the channel as loaded. The network channel has its own interrupt line, which raise and clear requests drive. Moving the data, translating addresses and routing interrupts happen elsewhere.

Top module: `dmactl_regs`

## Requirements
- R1: After reset, the disk control word (index 0) and the network control word (index 4) read 0xA0000000. The other six words read 0. Both interrupt lines, both reset pulses and `bus_rvalid` are low.
- R2: Any write to index 0 or index 4 stores the low 28 bits of the resulting value and forces bits [31:28] to 0xA. Index 4 stores its written low 28 bits unchanged.
- R3: When index 0 is written: if bit 7 is set, the value is kept as written; else if bit 6 is set, bit 6 is cleared; else if the whole word is zero, 0x40 is stored. Writing 0x40 therefore stores 0xA0000000.
- R4: A write with bit 7 set raises the matching reset output (index 0 to `disk_rst_pulse`, index 4 to `net_rst_pulse`) on the next clock for exactly one cycle.
- R5: A write to a control word with bit 4 (interrupt enable) clear drops that channel's interrupt line on the next clock. With bit 4 set, the line is left as it was.
- R6: Any write to index 1 (disk address) sets bit 26 (loaded) of index 0.
- R7: A `disk_done` event adds `disk_done_len` to index 1 and sets bit 0 (pending) of index 0. It does not change `disk_irq`.
- R8: `disk_irq_raise` sets bit 0 of index 0 and asserts `disk_irq`, and `disk_irq_clear` clears both. When both arrive in the same cycle, clear wins. `net_irq_raise` and `net_irq_clear` drive `net_irq` in the same way.
- R9: `disk_to_mem` reflects bit 8 of index 0 (1 means the transfer writes memory).
- R10: A read returns the word selected by address bits [4:2]; higher address bits and bits [1:0] are ignored. Data and `bus_rvalid` appear one cycle after `bus_rd`, and reads change no state.
- R11: When a CPU write to index 1 and a `disk_done` event fall in the same cycle, index 1 takes the written value and the increment is lost.
- R12: Indices 2, 3, 5, 6 and 7 store and return all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_addr | input | ADDR_W (8) | CPU byte address |
| bus_wdata | input | 32 | CPU write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| disk_irq_raise | input | 1 | Disk peripheral interrupt raise request |
| disk_irq_clear | input | 1 | Disk peripheral interrupt clear request |
| disk_done | input | 1 | Disk transfer completion event |
| disk_done_len | input | CNT_W (16) | Byte count of the completed transfer |
| net_irq_raise | input | 1 | Network interrupt raise request |
| net_irq_clear | input | 1 | Network interrupt clear request |
| disk_irq | output | 1 | Disk channel interrupt line |
| net_irq | output | 1 | Network channel interrupt line |
| disk_rst_pulse | output | 1 | One-cycle reset to the disk peripheral |
| net_rst_pulse | output | 1 | One-cycle reset to the network peripheral |
| disk_to_mem | output | 1 | Disk transfer direction (1 = into memory) |

## Verification
The disk address register has two writers that can act in the same cycle: the CPU bus and the completion-driven increment. The bench drives `bus_wr` to index 1 and `disk_done` in the same cycle. It then reads the word back and requires the written value with no count added. A later lone completion must advance from that written value. A simultaneous raise and clear request is also provoked, and the interrupt line must end low.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
  localparam int REG_W        = 32;
  localparam logic [3:0] VERSION_NIB = 4'hA;
  localparam int BIT_PEND     = 0;
  localparam int BIT_IE       = 4;
  localparam int BIT_SELF_CLR = 6;
  localparam int BIT_PRST     = 7;
  localparam int BIT_DIR      = 8;
  localparam int BIT_LOADED   = 26;

  localparam int IDX_DISK_CTRL = 0;
  localparam int IDX_DISK_ADDR = 1;
  localparam int IDX_NET_CTRL  = 4;

  localparam logic [REG_W-1:0] CTRL_RESET = {VERSION_NIB, 28'h0};

  function automatic logic [REG_W-1:0] stamp(input logic [REG_W-1:0] v);
    return {VERSION_NIB, v[REG_W-5:0]};
  endfunction

  function automatic logic [REG_W-1:0] disk_shape(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    r = v;
    if (v[BIT_PRST]) r = v;
    else if (v[BIT_SELF_CLR]) r[BIT_SELF_CLR] = 1'b0;
    else if (v == '0) r = 32'h40;
    return r;
  endfunction
endpackage

// File: rtl/dmactl_ctrl_reg.sv
module dmactl_ctrl_reg
  import dmactl_pkg::*;
#(
  parameter bit DISK_RULES = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             set_loaded,
  input  logic             pend_set,
  input  logic             pend_clr,
  input  logic             irq_raise,
  input  logic             irq_clr,
  output logic [REG_W-1:0] ctrl_q,
  output logic             irq_q,
  output logic             prst_q
);
  logic [REG_W-1:0] shaped;
  logic [REG_W-1:0] ctrl_n;
  logic             irq_n;

  generate
    if (DISK_RULES) begin : g_disk
      assign shaped = disk_shape(wr_data);
    end else begin : g_plain
      assign shaped = wr_data;
    end
  endgenerate

  always_comb begin
    ctrl_n = wr_en ? stamp(shaped) : ctrl_q;
    if (set_loaded) ctrl_n[BIT_LOADED] = 1'b1;
    if (pend_set)   ctrl_n[BIT_PEND]   = 1'b1;
    if (pend_clr)   ctrl_n[BIT_PEND]   = 1'b0;
  end

  always_comb begin
    irq_n = irq_q;
    if (wr_en && !wr_data[BIT_IE]) irq_n = 1'b0;
    if (irq_raise) irq_n = 1'b1;
    if (irq_clr)   irq_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
      irq_q  <= 1'b0;
      prst_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      irq_q  <= irq_n;
      prst_q <= wr_en && wr_data[BIT_PRST] && !prst_q;
    end
  end

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    prst_q |=> !prst_q);
  p_ie_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[BIT_IE] && !irq_raise) |=> !irq_q);
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
    irq_clr |=> !irq_q);
  p_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_raise && !irq_clr) |=> irq_q);
endmodule

// File: rtl/dmactl_addr_reg.sv
module dmactl_addr_reg
  import dmactl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             adv_en,
  input  logic [CNT_W-1:0] adv_len,
  output logic [REG_W-1:0] addr_q
);
  localparam int PAD_W = REG_W - CNT_W;

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (wr_en)  addr_q <= wr_data;
    else if (adv_en) addr_q <= addr_q + {{PAD_W{1'b0}}, adv_len};
  end

  p_cpu_wins_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> addr_q == $past(wr_data));
  p_advance_r7: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !wr_en) |=> addr_q == $past(addr_q) + {{PAD_W{1'b0}}, $past(adv_len)});
endmodule

// File: rtl/dmactl_regs.sv
module dmactl_regs
  import dmactl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              disk_irq_raise,
  input  logic              disk_irq_clear,
  input  logic              disk_done,
  input  logic [CNT_W-1:0]  disk_done_len,
  input  logic              net_irq_raise,
  input  logic              net_irq_clear,
  output logic              disk_irq,
  output logic              net_irq,
  output logic              disk_rst_pulse,
  output logic              net_rst_pulse,
  output logic              disk_to_mem
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0] idx;
  logic [NUM_REGS-1:0] wr_sel;
  logic [REG_W-1:0] view [NUM_REGS];
  logic [REG_W-1:0] disk_ctrl, disk_addr, net_ctrl;
  logic unused_addr_bits;

  assign idx = bus_addr[IDX_W+1:2];
  assign unused_addr_bits = ^{bus_addr[ADDR_W-1:IDX_W+2], bus_addr[1:0]};

  always_comb begin
    wr_sel = '0;
    if (bus_wr) wr_sel[idx] = 1'b1;
  end

  dmactl_ctrl_reg #(.DISK_RULES(1'b1)) u_disk_ctrl (
    .clk(clk), .rst(rst),
    .wr_en(wr_sel[IDX_DISK_CTRL]), .wr_data(bus_wdata),
    .set_loaded(wr_sel[IDX_DISK_ADDR]),
    .pend_set(disk_irq_raise | disk_done), .pend_clr(disk_irq_clear),
    .irq_raise(disk_irq_raise), .irq_clr(disk_irq_clear),
    .ctrl_q(disk_ctrl), .irq_q(disk_irq), .prst_q(disk_rst_pulse)
  );

  dmactl_addr_reg #(.CNT_W(CNT_W)) u_disk_addr (
    .clk(clk), .rst(rst),
    .wr_en(wr_sel[IDX_DISK_ADDR]), .wr_data(bus_wdata),
    .adv_en(disk_done), .adv_len(disk_done_len),
    .addr_q(disk_addr)
  );

  dmactl_ctrl_reg #(.DISK_RULES(1'b0)) u_net_ctrl (
    .clk(clk), .rst(rst),
    .wr_en(wr_sel[IDX_NET_CTRL]), .wr_data(bus_wdata),
    .set_loaded(1'b0), .pend_set(1'b0), .pend_clr(1'b0),
    .irq_raise(net_irq_raise), .irq_clr(net_irq_clear),
    .ctrl_q(net_ctrl), .irq_q(net_irq), .prst_q(net_rst_pulse)
  );

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (i == IDX_DISK_CTRL) begin : g_dc
        assign view[i] = disk_ctrl;
      end else if (i == IDX_DISK_ADDR) begin : g_da
        assign view[i] = disk_addr;
      end else if (i == IDX_NET_CTRL) begin : g_nc
        assign view[i] = net_ctrl;
      end else begin : g_plain
        logic [REG_W-1:0] q;
        always_ff @(posedge clk) begin
          if (rst)            q <= '0;
          else if (wr_sel[i]) q <= bus_wdata;
        end
        assign view[i] = q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= view[idx];
    end
  end

  assign disk_to_mem = disk_ctrl[BIT_DIR];

  p_loaded_r6: assert property (@(posedge clk) disable iff (rst)
    wr_sel[IDX_DISK_ADDR] |=> disk_ctrl[BIT_LOADED]);
  p_read_latency_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  p_done_pend_r7: assert property (@(posedge clk) disable iff (rst)
    (disk_done && !disk_irq_clear && !wr_sel[IDX_DISK_CTRL]) |=> disk_ctrl[BIT_PEND]);
endmodule

// File: tb/dmactl_regs_test.sv
`timescale 1ns/1ps
module dmactl_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic disk_irq_raise = 0, disk_irq_clear = 0, disk_done = 0;
  logic [15:0] disk_done_len = '0;
  logic net_irq_raise = 0, net_irq_clear = 0;
  logic disk_irq, net_irq, disk_rst_pulse, net_rst_pulse, disk_to_mem;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dmactl_regs uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .disk_irq_raise(disk_irq_raise), .disk_irq_clear(disk_irq_clear),
    .disk_done(disk_done), .disk_done_len(disk_done_len),
    .net_irq_raise(net_irq_raise), .net_irq_clear(net_irq_clear),
    .disk_irq(disk_irq), .net_irq(net_irq), .disk_rst_pulse(disk_rst_pulse),
    .net_rst_pulse(net_rst_pulse), .disk_to_mem(disk_to_mem)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    check("R10 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 disk_irq", {31'b0, disk_irq}, 0);
    check("R1 net_irq", {31'b0, net_irq}, 0);
    check("R1 pulses", {30'b0, disk_rst_pulse, net_rst_pulse}, 0);
    check("R1 rvalid", {31'b0, bus_rvalid}, 0);
    for (int i = 0; i < 8; i++) begin
      rd(8'(i * 4), v);
      check("R1 reset word", v, (i == 0 || i == 4) ? 32'hA000_0000 : 32'h0);
    end
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(8'h0C, 32'hDEAD_BEEF);
    rd(8'hEF, v);
    check("R12/R10 index3 via alias", v, 32'hDEAD_BEEF);
    wr(8'h1C, 32'h1234_5678);
    rd(8'h1C, v);
    check("R12 index7", v, 32'h1234_5678);
    rd(8'h3C, v);
    check("R10 upper bit ignored", v, 32'h1234_5678);
  endtask

  task automatic t_net_write();
    logic [31:0] v;
    wr(8'h10, 32'hFFFF_FFFF);
    check("R4 net pulse high", {31'b0, net_rst_pulse}, 1);
    check("R4 no disk pulse", {31'b0, disk_rst_pulse}, 0);
    @(negedge clk);
    check("R4 net pulse one cycle", {31'b0, net_rst_pulse}, 0);
    rd(8'h10, v);
    check("R2 net stamp", v, 32'hAFFF_FFFF);
    wr(8'h10, 32'h5000_0040);
    rd(8'h10, v);
    check("R2 net keeps bit6", v, 32'hA000_0040);
    check("R4 no pulse without bit7", {31'b0, net_rst_pulse}, 0);
  endtask

  task automatic t_disk_rules();
    logic [31:0] v;
    wr(8'h00, 32'h3000_0050); rd(8'h00, v);
    check("R3 bit6 cleared", v, 32'hA000_0010);
    wr(8'h00, 32'h0); rd(8'h00, v);
    check("R3 zero rewritten", v, 32'hA000_0040);
    wr(8'h00, 32'h40); rd(8'h00, v);
    check("R3 bit6-only write", v, 32'hA000_0000);
    wr(8'h00, 32'h0000_00C0);
    check("R4 disk pulse high", {31'b0, disk_rst_pulse}, 1);
    @(negedge clk);
    check("R4 disk pulse one cycle", {31'b0, disk_rst_pulse}, 0);
    rd(8'h00, v);
    check("R3 bit7 keeps value", v, 32'hA000_00C0);
  endtask

  task automatic t_loaded_done();
    logic [31:0] v;
    wr(8'h00, 32'h10);
    wr(8'h04, 32'h1000);
    rd(8'h00, v);
    check("R6 loaded bit", v, 32'hA400_0010);
    disk_done = 1; disk_done_len = 16'h20;
    @(negedge clk);
    disk_done = 0;
    check("R7 irq line untouched", {31'b0, disk_irq}, 0);
    rd(8'h04, v);
    check("R7 address advanced", v, 32'h1020);
    rd(8'h00, v);
    check("R7 pending set", v, 32'hA400_0011);
    rd(8'h00, v);
    check("R10 read has no side effect", v, 32'hA400_0011);
    @(negedge clk);
    check("R10 rvalid one cycle", {31'b0, bus_rvalid}, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    bus_addr = 8'h04; bus_wdata = 32'h2000; bus_wr = 1;
    disk_done = 1; disk_done_len = 16'h40;
    @(negedge clk);
    bus_wr = 0; disk_done = 0;
    rd(8'h04, v);
    check("R11 cpu write wins", v, 32'h2000);
    disk_done = 1; disk_done_len = 16'h40;
    @(negedge clk);
    disk_done = 0;
    rd(8'h04, v);
    check("R11 later advance from written value", v, 32'h2040);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h00, 32'h10);
    disk_irq_raise = 1; @(negedge clk); disk_irq_raise = 0;
    check("R8 raise asserts line", {31'b0, disk_irq}, 1);
    rd(8'h00, v);
    check("R8 raise sets pending", {31'b0, v[0]}, 1);
    disk_irq_clear = 1; @(negedge clk); disk_irq_clear = 0;
    check("R8 clear drops line", {31'b0, disk_irq}, 0);
    rd(8'h00, v);
    check("R8 clear drops pending", {31'b0, v[0]}, 0);
    disk_irq_raise = 1; disk_irq_clear = 1; @(negedge clk);
    disk_irq_raise = 0; disk_irq_clear = 0;
    check("R8 clear wins over raise", {31'b0, disk_irq}, 0);
    disk_irq_raise = 1; @(negedge clk); disk_irq_raise = 0;
    wr(8'h00, 32'h10);
    check("R5 IE set keeps line", {31'b0, disk_irq}, 1);
    wr(8'h00, 32'h20);
    check("R5 IE clear drops disk line", {31'b0, disk_irq}, 0);
    net_irq_raise = 1; @(negedge clk); net_irq_raise = 0;
    check("R8 net raise", {31'b0, net_irq}, 1);
    wr(8'h10, 32'h10);
    check("R5 net IE set keeps line", {31'b0, net_irq}, 1);
    wr(8'h10, 32'h0);
    check("R5 IE clear drops net line", {31'b0, net_irq}, 0);
    net_irq_raise = 1; @(negedge clk); net_irq_raise = 0;
    net_irq_clear = 1; @(negedge clk); net_irq_clear = 0;
    check("R8 net clear", {31'b0, net_irq}, 0);
  endtask

  task automatic t_dir();
    wr(8'h00, 32'h110);
    check("R9 direction to memory", {31'b0, disk_to_mem}, 1);
    wr(8'h00, 32'h10);
    check("R9 direction from memory", {31'b0, disk_to_mem}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_net_write();
    t_disk_rules();
    t_loaded_done();
    t_collide();
    t_irq();
    t_dir();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule